// File: doc/BRIEF.md
# Key Event Queue with Consuming and Indexed Reads

This block holds key events produced by a keypad scanner until a host drains them over a byte-oriented command interface. Each event is one byte: a 7-bit key code with the press/release state on top. Up to sixteen events are kept in a circular store, addressed by a head pointer and an occupancy count. Every accepted event raises a one-cycle keypad interrupt request toward the status logic. An event that arrives while the store is full is dropped, and a one-cycle overflow request goes to the error logic.

The host front end supplies a command code, a byte index and a read strobe. Two command codes are served. A consuming read (0x89) first discards the oldest event and then returns the event that became the oldest. It returns zero and changes nothing unless at least two events are held. An indexed peek (0x8A) returns the event at position head plus index, or zero past the occupancy, and leaves the store alone. A flush request from the configuration logic empties the store. While the error logic reports both its error flag and a sticky overflow bit, incoming events are thrown away without any signal.

Top module: `keyevt_fifo`

## Requirements
- R1: After a synchronous active-low reset, the count is 0, the full flag is 0, the read data is 0x00, and both request pulses are 0.
- R2: A stored event byte holds the key code in bits [6:0] and the press state (1 = pressed) in bit 7.
- R3: A push that is accepted appends the event behind the newest one, raises the count by one, and drives `irq_key_set` high for exactly the following cycle.
- R4: A push when the count is 16 is dropped, the count stays at 16, and `ovf_set` goes high for the following cycle.
- R5: When `err_flag` and `err_ovf_sticky` are both 1, a push is discarded with no pulse and no change of count. With only one of them set, pushes are handled normally.
- R6: A consuming read (command 0x89) with a count of 0 or 1 returns 0x00 and leaves the count and contents unchanged.
- R7: A consuming read with a count of 2 or more discards the oldest event, returns the next one, and lowers the count by one.
- R8: A peek (command 0x8A) with byte index n returns the event n places from the oldest when n is below the count, and 0x00 otherwise. It never changes the count or contents.
- R9: A flush empties the store and takes priority over a push and a read in the same cycle. The push is dropped silently, and the read returns 0x00.
- R10: A push and a valid consuming read in the same cycle leave the count unchanged, and both the returned byte and the later order of events are correct.
- R11: Event order is preserved across wrap-around of the 16-entry store.
- R12: `full` is 1 exactly when `count` equals 16.
- R13: A read strobe with any other command code returns 0x00 and changes nothing. `rd_data` holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Scanner offers an event this cycle |
| push_code | input | 7 | Key code of the offered event |
| push_press | input | 1 | 1 = press, 0 = release |
| err_flag | input | 1 | Error flag from the status logic |
| err_ovf_sticky | input | 1 | Sticky overflow bit from the error logic |
| flush | input | 1 | Empty the store (configuration write) |
| rd_strobe | input | 1 | Front end requests one read byte |
| rd_cmd | input | 8 | Current command code |
| rd_idx | input | 8 | Byte index within the current read |
| rd_data | output | 8 | Read byte, registered |
| irq_key_set | output | 1 | One-cycle pulse: event accepted |
| ovf_set | output | 1 | One-cycle pulse: event lost to a full store |
| count | output | 5 | Events held |
| full | output | 1 | Store holds 16 events |

## Verification
Every result is due one register stage after the edge that samples the stimulus. The read byte, the two request pulses, the count and the full flag all change at that edge and not later. The bench drives inputs just after a rising edge and updates its queue model at the next rising edge. It then compares all five outputs one nanosecond after that edge, so each comparison sees the result of exactly the stimulus just applied. Same-cycle collisions of push, read and flush are driven explicitly, so the priority rules are checked at the same single-cycle distance.

// File: rtl/keyevt_pkg.sv
// Package: shared command codes and event byte layout for the key event queue.
// Assumes: command codes are fixed by the host protocol decoder.
package keyevt_pkg;

    localparam logic [7:0] CMD_POP  = 8'h89;  // consuming read
    localparam logic [7:0] CMD_PEEK = 8'h8A;  // indexed, non-consuming read

    // Event byte: press state on top of a 7-bit key code.
    typedef struct packed {
        logic       press;
        logic [6:0] code;
    } key_evt_t;

endpackage

// File: rtl/keyevt_ptr.sv
// Module: keyevt_ptr
// Keeps the head pointer and occupancy count of the circular store and
// derives the write address for an accepted push.
// Assumes: DEPTH is a power of two; callers never assert pop_ok with count<2
// nor push_ok with a full store.
module keyevt_ptr #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_ok,
    input  logic             pop_ok,
    input  logic             flush,
    output logic [IDX_W-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic [IDX_W-1:0] wr_addr
);

    // Tail slot: head plus count, wrapping by pointer width.
    always_comb begin
        wr_addr = head + count[IDX_W-1:0];
    end

    // Head and count update; flush wins over any other activity.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            count <= '0;
        end else begin
            if (pop_ok) begin
                head <= head + IDX_W'(1);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/keyevt_store.sv
// Module: keyevt_store
// Event storage array with one write port and two combinational read ports.
// Assumes: entries are read only inside the occupied range, so no reset of
// the array contents is needed.
module keyevt_store #(
    parameter int DEPTH = 16,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write the accepted event into its slot.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Two independent combinational read ports.
    always_comb begin
        rdata_a = mem[raddr_a];
        rdata_b = mem[raddr_b];
    end

endmodule

// File: rtl/keyevt_rdsel.sv
// Module: keyevt_rdsel
// Chooses the next read byte from the command, the flush state and the
// occupancy, and holds it in the output register.
// Assumes: pop_ok already includes the count and flush qualification.
module keyevt_rdsel #(
    parameter int DATA_W = 8,
    parameter int IDXB_W = 8,
    parameter int CNT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              flush,
    input  logic              pop_ok,
    input  logic              is_peek,
    input  logic [IDXB_W-1:0] rd_idx,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] pop_byte,
    input  logic [DATA_W-1:0] peek_byte,
    output logic [DATA_W-1:0] rd_data
);

    localparam int CMP_W = (IDXB_W > CNT_W) ? IDXB_W : CNT_W;

    logic [CMP_W-1:0]  idx_ext;
    logic [CMP_W-1:0]  cnt_ext;
    logic              peek_hit;
    logic [DATA_W-1:0] next_byte;

    // Widen index and count to a common width before comparing.
    always_comb begin
        idx_ext  = CMP_W'(rd_idx);
        cnt_ext  = CMP_W'(count);
        peek_hit = is_peek && (idx_ext < cnt_ext);
    end

    // Select the byte the current strobe returns.
    always_comb begin
        if (flush) begin
            next_byte = '0;
        end else if (pop_ok) begin
            next_byte = pop_byte;
        end else if (peek_hit) begin
            next_byte = peek_byte;
        end else begin
            next_byte = '0;
        end
    end

    // Register the read byte; hold it between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_strobe) begin
            rd_data <= next_byte;
        end
    end

endmodule

// File: rtl/keyevt_fifo.sv
// Module: keyevt_fifo (top)
// Circular queue of key events with a consuming read and an indexed peek.
// Raises one-cycle requests for the keypad interrupt and the overflow error.
// Assumes: the error logic owns the sticky overflow bit and the error flag.
// The front end presents one read strobe per byte, with its command and index.
module keyevt_fifo #(
    parameter int DEPTH = 16,
    parameter int CODE_W = 7,
    parameter int IDXB_W = 8,
    localparam int DATA_W = CODE_W + 1,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [CODE_W-1:0] push_code,
    input  logic              push_press,
    input  logic              err_flag,
    input  logic              err_ovf_sticky,
    input  logic              flush,
    input  logic              rd_strobe,
    input  logic [7:0]        rd_cmd,
    input  logic [IDXB_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_key_set,
    output logic              ovf_set,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    import keyevt_pkg::*;

    logic              blocked;
    logic              push_try;
    logic              push_ok;
    logic              ovf_hit;
    logic              is_pop;
    logic              is_peek;
    logic              pop_ok;
    logic [IDX_W-1:0]  head;
    logic [IDX_W-1:0]  wr_addr;
    logic [IDX_W-1:0]  pop_addr;
    logic [IDX_W-1:0]  peek_addr;
    logic [DATA_W-1:0] pop_byte;
    logic [DATA_W-1:0] peek_byte;
    logic [DATA_W-1:0] evt_byte;

    // Decode push admission and read commands.
    always_comb begin
        blocked  = err_flag && err_ovf_sticky;
        full     = (count == CNT_W'(DEPTH));
        push_try = push_valid && !flush && !blocked;
        push_ok  = push_try && !full;
        ovf_hit  = push_try && full;
        is_pop   = rd_strobe && (rd_cmd == CMD_POP);
        is_peek  = rd_strobe && (rd_cmd == CMD_PEEK);
        pop_ok   = is_pop && !flush && (count > CNT_W'(1));
        evt_byte = {push_press, push_code};
    end

    // Read addresses: next oldest for a pop, head plus index for a peek.
    always_comb begin
        pop_addr  = head + IDX_W'(1);
        peek_addr = head + rd_idx[IDX_W-1:0];
    end

    // One-cycle request pulses toward the status and error logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_key_set <= 1'b0;
            ovf_set     <= 1'b0;
        end else begin
            irq_key_set <= push_ok;
            ovf_set     <= ovf_hit;
        end
    end

    keyevt_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .flush   (flush),
        .head    (head),
        .count   (count),
        .wr_addr (wr_addr)
    );

    keyevt_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .we      (push_ok),
        .waddr   (wr_addr),
        .wdata   (evt_byte),
        .raddr_a (pop_addr),
        .raddr_b (peek_addr),
        .rdata_a (pop_byte),
        .rdata_b (peek_byte)
    );

    keyevt_rdsel #(.DATA_W(DATA_W), .IDXB_W(IDXB_W), .CNT_W(CNT_W)) u_rdsel (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .flush     (flush),
        .pop_ok    (pop_ok),
        .is_peek   (is_peek),
        .rd_idx    (rd_idx),
        .count     (count),
        .pop_byte  (pop_byte),
        .peek_byte (peek_byte),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/keyevt_fifo_chk.sv
// Module: keyevt_fifo_chk
// Port-level temporal properties of the key event queue, bound to the top.
module keyevt_fifo_chk #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_valid,
    input logic              err_flag,
    input logic              err_ovf_sticky,
    input logic              flush,
    input logic              rd_strobe,
    input logic [7:0]        rd_cmd,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_key_set,
    input logic              ovf_set,
    input logic [CNT_W-1:0]  count,
    input logic              full
);

    // Count never exceeds the store depth (R12).
    a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // Full flag agrees with the count (R12).
    a_r12_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
        full == (count == CNT_W'(DEPTH)));

    // An admitted push into free space raises count and the keypad pulse (R3).
    a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !flush && !(err_flag && err_ovf_sticky) && !full && !rd_strobe)
        |=> (irq_key_set && count == $past(count) + CNT_W'(1)));

    // A push into a full store is dropped and reported (R4).
    a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !flush && !(err_flag && err_ovf_sticky) && full && !rd_strobe)
        |=> (ovf_set && !irq_key_set && full));

    // A blocked push leaves no trace (R5).
    a_r5_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && err_flag && err_ovf_sticky && !flush && !rd_strobe)
        |=> (!irq_key_set && !ovf_set && $stable(count)));

    // Consuming read with fewer than two entries returns zero, no change (R6).
    a_r6_short_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_cmd == 8'h89 && count <= CNT_W'(1) && !push_valid && !flush)
        |=> (rd_data == '0 && $stable(count)));

    // Flush empties the store and suppresses the push pulse (R9).
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0 && !irq_key_set && !ovf_set));

endmodule

bind keyevt_fifo keyevt_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .push_valid     (push_valid),
    .err_flag       (err_flag),
    .err_ovf_sticky (err_ovf_sticky),
    .flush          (flush),
    .rd_strobe      (rd_strobe),
    .rd_cmd         (rd_cmd),
    .rd_data        (rd_data),
    .irq_key_set    (irq_key_set),
    .ovf_set        (ovf_set),
    .count          (count),
    .full           (full)
);

// File: tb/keyevt_fifo_tb.sv
// Bench for keyevt_fifo: a queue-based reference model updated at each
// rising edge and compared with every output 1 ns later.
module keyevt_fifo_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [6:0] push_code = '0;
    logic       push_press = 1'b0;
    logic       err_flag = 1'b0;
    logic       err_ovf_sticky = 1'b0;
    logic       flush = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_cmd = '0;
    logic [7:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       irq_key_set;
    logic       ovf_set;
    logic [4:0] count;
    logic       full;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [7:0] mq[$];
    logic [7:0] exp_rd = 8'h00;
    bit         exp_irq = 1'b0;
    bit         exp_ovf = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    keyevt_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_code(push_code),
        .push_press(push_press), .err_flag(err_flag), .err_ovf_sticky(err_ovf_sticky),
        .flush(flush), .rd_strobe(rd_strobe), .rd_cmd(rd_cmd), .rd_idx(rd_idx),
        .rd_data(rd_data), .irq_key_set(irq_key_set), .ovf_set(ovf_set),
        .count(count), .full(full)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One clock: apply inputs, update the model at the edge, compare after it.
    task automatic step(input bit pv, input logic [6:0] code, input bit pr,
                        input bit ef, input bit eo, input bit fl,
                        input bit rs, input logic [7:0] cmd, input logic [7:0] idx,
                        input string tag);
        bit is_full;
        bit ptry;
        push_valid = pv; push_code = code; push_press = pr;
        err_flag = ef; err_ovf_sticky = eo; flush = fl;
        rd_strobe = rs; rd_cmd = cmd; rd_idx = idx;
        @(posedge clk);
        is_full = (mq.size() == 16);
        ptry    = pv && !fl && !(ef && eo);
        exp_irq = ptry && !is_full;
        exp_ovf = ptry && is_full;
        if (rs) begin
            if (fl) exp_rd = 8'h00;
            else if (cmd == 8'h89) begin
                if (mq.size() > 1) begin
                    void'(mq.pop_front());
                    exp_rd = mq[0];
                end else exp_rd = 8'h00;
            end else if (cmd == 8'h8A) begin
                exp_rd = (int'(idx) < mq.size()) ? mq[idx] : 8'h00;
            end else exp_rd = 8'h00;
        end
        if (exp_irq) mq.push_back({pr, code});
        if (fl) mq.delete();
        #1;
        check({tag, " rd_data"}, rd_data, exp_rd);
        check({tag, " count R12"}, count, mq.size());
        check({tag, " full R12"}, full, mq.size() == 16);
        check({tag, " irq R3"}, irq_key_set, exp_irq);
        check({tag, " ovf R4"}, ovf_set, exp_ovf);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 0, 0, 8'h00, 0, tag);
    endtask

    task automatic push(input logic [6:0] c, input bit pr, input string tag);
        step(1, c, pr, 0, 0, 0, 0, 8'h00, 0, tag);
    endtask

    task automatic pop(input string tag);
        step(0, 0, 0, 0, 0, 0, 1, 8'h89, 0, tag);
    endtask

    task automatic peek(input logic [7:0] n, input string tag);
        step(0, 0, 0, 0, 0, 0, 1, 8'h8A, n, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state.
        check("R1 count", count, 0);
        check("R1 full", full, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 irq", irq_key_set, 0);
        check("R1 ovf", ovf_set, 0);
        rst_n = 1'b1;

        // R6: consuming read on empty, then with one entry.
        pop("R6 empty pop");
        push(7'h3C, 1, "R2 R3 push press");
        pop("R6 single pop");
        // R2, R3: more events, then peek all slots and past the end (R8).
        push(7'h55, 0, "R2 R3 push release");
        push(7'h01, 1, "R3 push");
        for (int i = 0; i < 5; i++) peek(8'(i), "R8 peek");
        peek(8'hFF, "R8 peek far");
        // R13: unknown command, then hold without strobe.
        step(0, 0, 0, 0, 0, 0, 1, 8'h8C, 0, "R13 other cmd");
        peek(8'd1, "R8 peek again");
        idle("R13 hold");
        // R7: drain to one, then R6 again.
        pop("R7 pop");
        pop("R7 pop");
        pop("R6 pop at one");

        // R4, R12: fill to 16 and overflow.
        for (int i = 0; i < 16; i++) push(7'(8'h10 + i), i[0], "R12 fill");
        push(7'h7F, 1, "R4 overflow");
        push(7'h7E, 0, "R4 overflow again");
        peek(8'd15, "R8 peek last");

        // R5: blocked push when both error inputs are set; single ones pass.
        for (int i = 0; i < 4; i++) pop("R7 drain");
        step(1, 7'h22, 1, 1, 1, 0, 0, 8'h00, 0, "R5 blocked");
        step(1, 7'h23, 1, 1, 0, 0, 0, 8'h00, 0, "R5 flag only");
        step(1, 7'h24, 0, 0, 1, 0, 0, 8'h00, 0, "R5 sticky only");
        peek(8'd13, "R5 peek tail");

        // R10: push and consuming read together.
        for (int i = 0; i < 6; i++) step(1, 7'(8'h40 + i), 1, 0, 0, 0, 1, 8'h89, 0, "R10 push+pop");

        // R11: wrap-around with varied occupancy.
        for (int i = 0; i < 40; i++) begin
            if (i % 3 == 0) pop("R11 wrap pop");
            else push(7'((i * 13) & 8'h7F), i[1], "R11 wrap push");
        end
        for (int i = 0; i < 4; i++) peek(8'(i), "R11 wrap peek");

        // R9: flush with push and pop in the same cycle.
        step(1, 7'h11, 1, 0, 0, 1, 1, 8'h89, 0, "R9 flush");
        pop("R9 pop after flush");
        push(7'h33, 0, "R9 push after flush");
        push(7'h34, 1, "R9 push after flush");
        pop("R9 pop order");
        step(1, 7'h35, 0, 0, 0, 1, 1, 8'h8A, 0, "R9 flush peek");
        peek(8'd0, "R9 peek empty");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule